// File: doc/BRIEF.md
# Dual-Clock FIFO with Half-Full Flag

This block is a 16-entry first-in first-out buffer that connects two unrelated clock domains running at roughly the same rate. The producer pushes words on its own clock and sees a full flag on that clock. The consumer pops words on its own clock. On that side it sees an empty flag and a registered half-full flag.

Each side owns a binary pointer with one extra wrap bit. A Gray-coded copy of each pointer is handed across to the other domain through a flop synchroniser. In the read domain, the arriving write pointer is turned back into binary and the read pointer is subtracted from it. The difference is the occupancy, and the empty and half-full flags come from it. In the write domain, the arriving read pointer is compared with the local write pointer to detect full.

The read data port is show-ahead: while the FIFO is not empty, it presents the oldest unread word without waiting for a read strobe.

Top module: `dcfifo_hf`

## Requirements
- R1: After reset, `rdEmpty` is 1, `wrFull` is 0 and `rdHalfFull` is 0.
- R2: Words leave in the order they were written. While `rdEmpty` is 0, `rdData` shows the oldest unread word, and a read strobe moves on to the next one.
- R3: A write strobe while `wrFull` is 1 stores nothing and does not move the write pointer.
- R4: A read strobe while `rdEmpty` is 1 does not move the read pointer. The next word written is the next word read.
- R5: After 16 unread writes, `wrFull` is 1. Once reads have crossed the synchroniser, it returns to 0.
- R6: Once a write has crossed the synchroniser, `rdEmpty` falls within a few read clocks. When every written word has been read, it is 1 again.
- R7: Once pointers have settled, `rdHalfFull` is 1 when 8 or more words are held and 0 when 7 or fewer are held.
- R8: Each Gray pointer handed across domains changes in at most one bit per clock.
- R9: The read-side occupancy never exceeds 16.
- R10: Pointers wrap modulo 32 with the 4 low bits addressing storage, so data stays correct across many fill and drain rounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| wrRstN | input | 1 | Write-side asynchronous reset, active low |
| wrEn | input | 1 | Write strobe |
| wrData | input | DATA_W | Word to store |
| wrFull | output | 1 | FIFO full, in the write domain |
| rdClk | input | 1 | Read-side clock |
| rdRstN | input | 1 | Read-side asynchronous reset, active low |
| rdEn | input | 1 | Read strobe |
| rdData | output | DATA_W | Oldest unread word (show-ahead) |
| rdEmpty | output | 1 | FIFO empty, in the read domain |
| rdHalfFull | output | 1 | Registered flag: 8 or more words held |

## Verification
A corrupted pointer or synchroniser stage shows at the ports as a wrong word on `rdData`, or as a flag that disagrees with the known fill level. Either appears a few read clocks after the flags settle.

The bench sweeps every fill level from 0 to 16 and drains each level one word at a time, so pointers pass the wrap point many times. After every step it compares the flags with the level. A lost write or an extra pointer step therefore shows on the very next word popped.

// File: rtl/fifo_pkg.sv
package fifo_pkg;
  parameter int unsigned FifoAddrW = 4;

  typedef struct packed {
    logic                 wrStrobe;
    logic [FifoAddrW-1:0] wrAddr;
    logic [FifoAddrW-1:0] rdAddr;
  } strobe_t;
endpackage

// File: rtl/fifo_sync.sv
module fifo_sync #(
  parameter int unsigned W      = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stg[i] <= '0;
        else if (i == 0) stg[i] <= d;
        else stg[i] <= stg[(i == 0) ? 0 : i - 1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/fifo_store.sv
module fifo_store
  import fifo_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              wrClk,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int unsigned Depth = 1 << FifoAddrW;

  logic [DATA_W-1:0] mem [Depth];

  always_ff @(posedge wrClk) begin
    if (strb.wrStrobe) mem[strb.wrAddr] <= wrData;
  end

  assign rdData = mem[strb.rdAddr];
endmodule

// File: rtl/fifo_ctrl.sv
module fifo_ctrl
  import fifo_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic    wrClk,
  input  logic    wrRstN,
  input  logic    wrEn,
  output logic    wrFull,
  input  logic    rdClk,
  input  logic    rdRstN,
  input  logic    rdEn,
  output logic    rdEmpty,
  output logic    rdHalfFull,
  output strobe_t strb
);
  localparam int unsigned AW    = FifoAddrW;
  localparam int unsigned PW    = AW + 1;
  localparam int unsigned Depth = 1 << AW;
  localparam int unsigned Half  = Depth / 2;
  localparam logic [PW-1:0] WrapFlip = {1'b1, {AW{1'b0}}};

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] toBin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // write domain
  logic [PW-1:0] wrBin, wrGray, rdGrayAtW, rdBinAtW, wrBinNext;
  logic          wrGo;

  assign wrBinNext = wrBin + 1'b1;
  assign wrGo      = wrEn && !wrFull;

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      wrBin  <= '0;
      wrGray <= '0;
    end else if (wrGo) begin
      wrBin  <= wrBinNext;
      wrGray <= toGray(wrBinNext);
    end
  end

  // read domain
  logic [PW-1:0] rdBin, rdGray, wrGrayAtR, wrBinAtR, rdBinNext, occ;
  logic          rdGo;

  fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_syncRdToWr (
    .clk(wrClk), .rstN(wrRstN), .d(rdGray), .q(rdGrayAtW)
  );
  fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_syncWrToRd (
    .clk(rdClk), .rstN(rdRstN), .d(wrGray), .q(wrGrayAtR)
  );

  assign rdBinAtW = toBin(rdGrayAtW);
  assign wrFull   = (wrBin == (rdBinAtW ^ WrapFlip));

  assign wrBinAtR  = toBin(wrGrayAtR);
  assign occ       = wrBinAtR - rdBin;
  assign rdEmpty   = (occ == '0);
  assign rdBinNext = rdBin + 1'b1;
  assign rdGo      = rdEn && !rdEmpty;

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rdBin      <= '0;
      rdGray     <= '0;
      rdHalfFull <= 1'b0;
    end else begin
      rdHalfFull <= (occ >= PW'(Half));
      if (rdGo) begin
        rdBin  <= rdBinNext;
        rdGray <= toGray(rdBinNext);
      end
    end
  end

  assign strb.wrStrobe = wrGo;
  assign strb.wrAddr   = wrBin[AW-1:0];
  assign strb.rdAddr   = rdBin[AW-1:0];

  // R3
  no_overflow_chk: assert property (@(posedge wrClk) disable iff (!wrRstN)
    wrFull |=> (wrBin == $past(wrBin)));
  // R4
  no_underflow_chk: assert property (@(posedge rdClk) disable iff (!rdRstN)
    rdEmpty |=> (rdBin == $past(rdBin)));
  // R8
  wr_gray_step_chk: assert property (@(posedge wrClk) disable iff (!wrRstN)
    $countones(wrGray ^ $past(wrGray)) <= 1);
  // R8
  rd_gray_step_chk: assert property (@(posedge rdClk) disable iff (!rdRstN)
    $countones(rdGray ^ $past(rdGray)) <= 1);
  // R9
  occ_range_chk: assert property (@(posedge rdClk) disable iff (!rdRstN)
    occ <= PW'(Depth));
endmodule

// File: rtl/dcfifo_hf.sv
module dcfifo_hf
  import fifo_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrFull,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdEmpty,
  output logic              rdHalfFull
);
  strobe_t strb;

  fifo_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrEn(wrEn), .wrFull(wrFull),
    .rdClk(rdClk), .rdRstN(rdRstN), .rdEn(rdEn), .rdEmpty(rdEmpty),
    .rdHalfFull(rdHalfFull), .strb(strb)
  );

  fifo_store #(.DATA_W(DATA_W)) u_store (
    .wrClk(wrClk), .strb(strb), .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: tb/sim_dcfifo_hf.sv
module sim_dcfifo_hf;
  logic wrClk = 1'b0, rdClk = 1'b0;
  logic wrRstN = 1'b0, rdRstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic wrFull, rdEmpty, rdHalfFull;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 wrClk = ~wrClk;
  always #11.5 rdClk = ~rdClk;

  dcfifo_hf u0 (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrEn(wrEn), .wrData(wrData), .wrFull(wrFull),
    .rdClk(rdClk), .rdRstN(rdRstN), .rdEn(rdEn), .rdData(rdData),
    .rdEmpty(rdEmpty), .rdHalfFull(rdHalfFull)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] v);
    @(negedge wrClk);
    wrEn = 1'b1; wrData = v;
    @(negedge wrClk);
    wrEn = 1'b0;
  endtask

  task automatic pop();
    @(negedge rdClk);
    rdEn = 1'b1;
    @(negedge rdClk);
    rdEn = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(negedge rdClk);
    repeat (6) @(negedge wrClk);
    @(negedge rdClk);
  endtask

  task automatic flags(input int level);
    chk("R6 empty", int'(rdEmpty), int'(level == 0));
    chk("R7 halffull", int'(rdHalfFull), int'(level >= 8));
    @(negedge wrClk);
    chk("R5 full", int'(wrFull), int'(level == 16));
    @(negedge rdClk);
  endtask

  initial begin
    repeat (3) @(negedge wrClk);
    // R1
    chk("R1 empty", int'(rdEmpty), 1);
    chk("R1 full", int'(wrFull), 0);
    chk("R1 halffull", int'(rdHalfFull), 0);
    wrRstN = 1'b1; rdRstN = 1'b1;
    settle();

    // R2 R5 R6 R7 R10: every fill level, drained one word at a time
    for (int n = 0; n <= 16; n++) begin
      for (int i = 0; i < n; i++) push(8'((n * 17 + i) & 8'hFF));
      settle();
      flags(n);
      for (int i = 0; i < n; i++) begin
        chk("R2 R10 data", int'(rdData), (n * 17 + i) & 8'hFF);
        pop();
        settle();
        flags(n - i - 1);
      end
    end

    // R3: write while full is dropped
    for (int i = 0; i < 16; i++) push(8'(8'h30 + i));
    settle();
    chk("R3 full", int'(wrFull), 1);
    push(8'hEE);
    settle();
    for (int i = 0; i < 16; i++) begin
      chk("R3 data", int'(rdData), 8'h30 + i);
      pop();
    end
    settle();
    chk("R3 empty after drain", int'(rdEmpty), 1);

    // R4: read while empty is ignored
    pop();
    pop();
    push(8'h5A);
    push(8'hA5);
    settle();
    chk("R4 data", int'(rdData), 8'h5A);
    pop();
    settle();
    chk("R4 data2", int'(rdData), 8'hA5);
    pop();
    settle();
    chk("R4 empty", int'(rdEmpty), 1);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 200000) begin
      @(posedge wrClk);
      cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule